// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous parallel flash bus. The bus has a 17-bit address, an 8-bit data path split into output, input and output-enable, and active-low chip select (CE), read strobe (OE) and write strobe (WE). A client hands over one request: either write one byte at an address, or erase the whole array. The block then issues every bus write of the matching unlock command sequence. Each write pulse has its own set-up, low-time and high-time phase. The length of each phase is derived from a nanosecond minimum and the clock period, with the cycle count rounded up.

After the last write, the block turns the data bus around and reads the polled address again and again. It stops when bit 7 of the returned byte equals bit 7 of the value that was written, which is 1 for an erase. If a per-operation cycle budget runs out first, it stops with an error. The outcome is returned on a valid/ready response channel. A new request is accepted only once that response has been consumed.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset, CE, OE and WE are high, the data output enable is low, reqReady is high and rspValid is low.
- R2: A program request produces exactly four bus writes, as address/data pairs in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then the requested address with the requested byte.
- R3: An erase request (reqErase=1) produces exactly six bus writes, in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10.
- R4: Every WE low pulse lasts exactly ceil(WE_LOW_NS/CLK_PERIOD_NS) cycles. Between two pulses of one operation, WE stays high for at least ceil(WE_HIGH_NS/CLK_PERIOD_NS) cycles.
- R5: The address and write data stay constant for the whole of each WE low pulse.
- R6: OE is never low while WE is low, and CE is low whenever WE or OE is low.
- R7: The data output enable is never high while OE is low, and it is low in the cycle before OE falls.
- R8: Polling reads the last address of the sequence. The response is given with rspError=0 once a read returns bit 7 equal to bit 7 of the written byte (1 for erase), and not before.
- R9: If no poll read matches within PROG_TIMEOUT_CYC cycles after the last write (ERASE_TIMEOUT_CYC for erase), the response is given with rspError=1.
- R10: reqReady is high only while the block is idle. A response stays valid with a stable error flag until rspReady is high, and then the block is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqErase | input | 1 | 1 = erase the whole array, 0 = program one byte |
| reqAddr | input | 17 | Byte address to program |
| reqData | input | 8 | Byte to program |
| rspValid | output | 1 | Operation finished |
| rspReady | input | 1 | Response consumed |
| rspError | output | 1 | 1 = polling timed out |
| flAddr | output | 17 | Flash address bus |
| flDqOut | output | 8 | Flash data driven by the block |
| flDqOe | output | 1 | Drive enable for flDqOut |
| flDqIn | input | 8 | Flash data read back |
| flCeN | output | 1 | Flash chip select, active low |
| flOeN | output | 1 | Flash read strobe, active low |
| flWeN | output | 1 | Flash write strobe, active low |

## Verification
The bench runs program requests with random addresses and data against a flash model that returns inverted bit 7 for a random number of cycles. This separates an early or late completion from a correct one, and shows whether the polled bit is compared with the right polarity for bytes whose top bit is 0 and 1. Directed cases add a model that is ready at once, which exposes an off-by-one at the first poll. They add erase requests, which tell the six-write sequence and its all-ones poll target apart from the program path. They add a model that never finishes, for both operation types, which tells the two timeout budgets apart and confirms that the error flag is set. On every operation, the pulse widths, the WE-high gaps, the strobe overlaps, the bus turnaround and the handshake are measured at the pins.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned STEP_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WSETUP, ST_WLOW, ST_WHIGH,
    ST_PTURN, ST_PREAD, ST_PCHK, ST_PGAP, ST_RESP
  } seqState_e;

  typedef enum logic [2:0] {
    CNT_SETUP, CNT_LOW, CNT_HIGH, CNT_READ, CNT_GAP
  } cntSel_e;

  typedef struct packed {
    logic    accept;
    logic    cntLoad;
    cntSel_e cntSel;
    logic    stepNext;
    logic    toRun;
    logic    capture;
    logic    setErr;
  } seqStrobe_t;

  function automatic int unsigned cyclesFor(input int unsigned ns, input int unsigned period);
    int unsigned r;
    r = (ns + period - 1) / period;
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/flash_seq_path.sv
module flash_seq_path
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W            = 17,
  parameter int unsigned CLK_PERIOD_NS     = 8,
  parameter int unsigned WE_LOW_NS         = 200,
  parameter int unsigned WE_HIGH_NS        = 200,
  parameter int unsigned SETUP_CYC         = 1,
  parameter int unsigned OE_ACCESS_NS      = 60,
  parameter int unsigned OE_HIGH_NS        = 150,
  parameter int unsigned PROG_TIMEOUT_CYC  = 100000,
  parameter int unsigned ERASE_TIMEOUT_CYC = 1250000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] flDqIn,
  output logic              cntZero,
  output logic              lastStep,
  output logic              toExpired,
  output logic              pollOk,
  output logic              rspError,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData
);

  localparam int unsigned LowCyc   = cyclesFor(WE_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned HighCyc  = cyclesFor(WE_HIGH_NS, CLK_PERIOD_NS);
  localparam int unsigned ReadCyc  = cyclesFor(OE_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned GapCyc   = cyclesFor(OE_HIGH_NS, CLK_PERIOD_NS);
  localparam int unsigned SetCyc   = (SETUP_CYC == 0) ? 1 : SETUP_CYC;
  localparam int unsigned MaxA     = (LowCyc > HighCyc) ? LowCyc : HighCyc;
  localparam int unsigned MaxB     = (ReadCyc > GapCyc) ? ReadCyc : GapCyc;
  localparam int unsigned MaxC     = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int unsigned MaxCyc   = (MaxC > SetCyc) ? MaxC : SetCyc;
  localparam int unsigned PhaseW   = $clog2(MaxCyc + 1);
  localparam int unsigned MaxTo    = (PROG_TIMEOUT_CYC > ERASE_TIMEOUT_CYC) ? PROG_TIMEOUT_CYC : ERASE_TIMEOUT_CYC;
  localparam int unsigned ToW      = $clog2(MaxTo + 1);
  localparam logic [ADDR_W-1:0] CmdA = ADDR_W'(17'h05555);
  localparam logic [ADDR_W-1:0] CmdB = ADDR_W'(17'h02AAA);

  logic              opErase;
  logic [ADDR_W-1:0] tgtAddr;
  logic [DATA_W-1:0] tgtData;
  logic [STEP_W-1:0] stepIdx;
  logic [PhaseW-1:0] phaseCnt;
  logic [PhaseW-1:0] phaseLoad;
  logic [ToW-1:0]    toCnt;
  logic [ToW-1:0]    toLimit;
  logic [DATA_W-1:0] readByte;
  logic              errReg;

  // command sequence lookup: address and data for the current step
  always_comb begin
    busAddr = CmdA;
    busData = 8'hAA;
    if (opErase) begin
      case (stepIdx)
        3'd0:    begin busAddr = CmdA; busData = 8'hAA; end
        3'd1:    begin busAddr = CmdB; busData = 8'h55; end
        3'd2:    begin busAddr = CmdA; busData = 8'h80; end
        3'd3:    begin busAddr = CmdA; busData = 8'hAA; end
        3'd4:    begin busAddr = CmdB; busData = 8'h55; end
        default: begin busAddr = CmdA; busData = 8'h10; end
      endcase
    end else begin
      case (stepIdx)
        3'd0:    begin busAddr = CmdA;    busData = 8'hAA; end
        3'd1:    begin busAddr = CmdB;    busData = 8'h55; end
        3'd2:    begin busAddr = CmdA;    busData = 8'hA0; end
        default: begin busAddr = tgtAddr; busData = tgtData; end
      endcase
    end
  end

  assign lastStep = opErase ? (stepIdx == STEP_W'(5)) : (stepIdx == STEP_W'(3));

  always_comb begin
    case (strobe.cntSel)
      CNT_SETUP: phaseLoad = PhaseW'(SetCyc - 1);
      CNT_LOW:   phaseLoad = PhaseW'(LowCyc - 1);
      CNT_HIGH:  phaseLoad = PhaseW'(HighCyc - 1);
      CNT_READ:  phaseLoad = PhaseW'(ReadCyc - 1);
      default:   phaseLoad = PhaseW'(GapCyc - 1);
    endcase
  end

  assign cntZero   = (phaseCnt == '0);
  assign toLimit   = opErase ? ToW'(ERASE_TIMEOUT_CYC) : ToW'(PROG_TIMEOUT_CYC);
  assign toExpired = (toCnt >= toLimit);
  assign pollOk    = opErase ? readByte[DATA_W-1] : (readByte[DATA_W-1] == tgtData[DATA_W-1]);
  assign rspError  = errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opErase  <= 1'b0;
      tgtAddr  <= '0;
      tgtData  <= '0;
      stepIdx  <= '0;
      phaseCnt <= '0;
      toCnt    <= '0;
      readByte <= '0;
      errReg   <= 1'b0;
    end else begin
      if (strobe.accept) begin
        opErase <= reqErase;
        tgtAddr <= reqAddr;
        tgtData <= reqData;
        stepIdx <= '0;
        toCnt   <= '0;
        errReg  <= 1'b0;
      end
      if (strobe.cntLoad)      phaseCnt <= phaseLoad;
      else if (!cntZero)       phaseCnt <= phaseCnt - 1'b1;
      if (strobe.stepNext)     stepIdx  <= stepIdx + 1'b1;
      if (strobe.toRun && !toExpired) toCnt <= toCnt + 1'b1;
      if (strobe.capture)      readByte <= flDqIn;
      if (strobe.setErr)       errReg   <= 1'b1;
    end
  end

  AST_STEP_IN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepNext |-> !lastStep); // R2
  AST_ERR_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setErr |-> (toExpired && !pollOk)); // R9

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  input  logic       rspReady,
  input  logic       cntZero,
  input  logic       lastStep,
  input  logic       toExpired,
  input  logic       pollOk,
  output seqStrobe_t strobe,
  output logic       flCeN,
  output logic       flOeN,
  output logic       flWeN,
  output logic       flDqOe
);

  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.accept  = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = CNT_SETUP;
        stateNext      = ST_WSETUP;
      end
      ST_WSETUP: if (cntZero) begin
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = CNT_LOW;
        stateNext      = ST_WLOW;
      end
      ST_WLOW: if (cntZero) begin
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = CNT_HIGH;
        stateNext      = ST_WHIGH;
      end
      ST_WHIGH: if (cntZero) begin
        if (lastStep) begin
          stateNext = ST_PTURN;
        end else begin
          strobe.stepNext = 1'b1;
          strobe.cntLoad  = 1'b1;
          strobe.cntSel   = CNT_SETUP;
          stateNext       = ST_WSETUP;
        end
      end
      ST_PTURN: begin
        strobe.toRun   = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = CNT_READ;
        stateNext      = ST_PREAD;
      end
      ST_PREAD: begin
        strobe.toRun = 1'b1;
        if (cntZero) begin
          strobe.capture = 1'b1;
          stateNext      = ST_PCHK;
        end
      end
      ST_PCHK: begin
        strobe.toRun = 1'b1;
        if (pollOk) begin
          stateNext = ST_RESP;
        end else if (toExpired) begin
          strobe.setErr = 1'b1;
          stateNext     = ST_RESP;
        end else begin
          strobe.cntLoad = 1'b1;
          strobe.cntSel  = CNT_GAP;
          stateNext      = ST_PGAP;
        end
      end
      ST_PGAP: begin
        strobe.toRun = 1'b1;
        if (cntZero) begin
          strobe.cntLoad = 1'b1;
          strobe.cntSel  = CNT_READ;
          stateNext      = ST_PREAD;
        end
      end
      ST_RESP: if (rspReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign flCeN    = (state == ST_IDLE) || (state == ST_RESP);
  assign flWeN    = (state != ST_WLOW);
  assign flOeN    = (state != ST_PREAD);
  assign flDqOe   = (state == ST_WSETUP) || (state == ST_WLOW) || (state == ST_WHIGH);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid); // R10
  AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> reqReady); // R10

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W            = 17,
  parameter int unsigned CLK_PERIOD_NS     = 8,
  parameter int unsigned WE_LOW_NS         = 200,
  parameter int unsigned WE_HIGH_NS        = 200,
  parameter int unsigned SETUP_CYC         = 1,
  parameter int unsigned OE_ACCESS_NS      = 60,
  parameter int unsigned OE_HIGH_NS        = 150,
  parameter int unsigned PROG_TIMEOUT_CYC  = 100000,
  parameter int unsigned ERASE_TIMEOUT_CYC = 1250000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspError,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDqOut,
  output logic              flDqOe,
  input  logic [7:0]        flDqIn,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);

  seqStrobe_t strobe;
  logic cntZero, lastStep, toExpired, pollOk;

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady), .cntZero(cntZero),
    .lastStep(lastStep), .toExpired(toExpired), .pollOk(pollOk),
    .strobe(strobe), .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN), .flDqOe(flDqOe)
  );

  flash_seq_path #(
    .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .WE_LOW_NS(WE_LOW_NS),
    .WE_HIGH_NS(WE_HIGH_NS), .SETUP_CYC(SETUP_CYC), .OE_ACCESS_NS(OE_ACCESS_NS),
    .OE_HIGH_NS(OE_HIGH_NS), .PROG_TIMEOUT_CYC(PROG_TIMEOUT_CYC),
    .ERASE_TIMEOUT_CYC(ERASE_TIMEOUT_CYC)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqErase(reqErase),
    .reqAddr(reqAddr), .reqData(reqData), .flDqIn(flDqIn), .cntZero(cntZero),
    .lastStep(lastStep), .toExpired(toExpired), .pollOk(pollOk),
    .rspError(rspError), .busAddr(flAddr), .busData(flDqOut)
  );

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!flWeN && !flOeN)); // R6
  AST_CE_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN || !flOeN) |-> !flCeN); // R6
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flOeN) |-> $past(!flDqOe)); // R7
  AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDqOut))); // R5
  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(rspValid)) |-> $stable(rspError)); // R10

endmodule

// File: tb/sim_flash_wr_seq.sv
module sim_flash_wr_seq;

  localparam int unsigned PER = 8;
  localparam int unsigned PROG_TO = 2000;
  localparam int unsigned ERASE_TO = 4000;
  localparam int LOW_EXP  = (200 + PER - 1) / PER;
  localparam int HIGH_EXP = (200 + PER - 1) / PER;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqErase = 1'b0, rspReady = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic reqReady, rspValid, rspError, flDqOe, flCeN, flOeN, flWeN;
  logic [16:0] flAddr;
  logic [7:0]  flDqOut, flDqIn;

  always #(PER/2) clk = ~clk;

  flash_wr_seq #(.CLK_PERIOD_NS(PER), .PROG_TIMEOUT_CYC(PROG_TO),
                 .ERASE_TIMEOUT_CYC(ERASE_TO)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqErase(reqErase), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspReady(rspReady), .rspError(rspError),
    .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe), .flDqIn(flDqIn),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

  int total = 0, bad = 0, cyc = 0;
  // flash model state
  bit curErase, stuck;
  int curBusy, busyLeft;
  logic [7:0] modelData = 8'hFF;
  int wrCnt, lowRun, highRun, lowBad, gapBad, oeWeBad, dqOeBad, stabBad, riseCyc;
  logic [16:0] wrAddr [8];
  logic [7:0]  wrData [8];
  logic prevWeN = 1'b1, prevOeN = 1'b1, prevDqOe = 1'b0;
  logic [16:0] prevAddr;
  logic [7:0]  prevDout;

  assign flDqIn = (stuck || busyLeft != 0) ? {~modelData[7], modelData[6:0]} : modelData;

  function automatic int expCount(bit e);
    return e ? 6 : 4;
  endfunction
  function automatic logic [16:0] expAddr(bit e, int i, logic [16:0] a);
    if (e) return (i == 1 || i == 4) ? 17'h02AAA : 17'h05555;
    return (i == 3) ? a : ((i == 1) ? 17'h02AAA : 17'h05555);
  endfunction
  function automatic logic [7:0] expData(bit e, int i, logic [7:0] d);
    logic [7:0] pe [6];
    logic [7:0] pp [3];
    pe = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    pp = '{8'hAA, 8'h55, 8'hA0};
    if (e) return pe[i];
    return (i == 3) ? d : pp[i];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pin monitor and flash model, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "WDG", "watchdog expired", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rstN) begin
      if (busyLeft > 0) busyLeft--;
      if (!flWeN && !flOeN) oeWeBad++;
      if (!flOeN && flDqOe) oeWeBad += 0;
      if (!flOeN && flDqOe) dqOeBad++;
      if (!flOeN && prevOeN && prevDqOe) dqOeBad++;
      if ((!flWeN || !flOeN) && flCeN) oeWeBad++;
      if (!flWeN) begin
        if (prevWeN) begin
          if (wrCnt > 0 && highRun < HIGH_EXP) gapBad++;
          lowRun = 0;
        end else if (flAddr != prevAddr || flDqOut != prevDout) stabBad++;
        lowRun++;
        if (wrCnt < 8) begin wrAddr[wrCnt] = flAddr; wrData[wrCnt] = flDqOut; end
      end else begin
        if (!prevWeN) begin
          if (lowRun != LOW_EXP) lowBad++;
          wrCnt++;
          highRun = 0;
          if (wrCnt == expCount(curErase)) begin
            busyLeft  = curBusy;
            modelData = curErase ? 8'hFF : wrData[3];
            riseCyc   = cyc;
          end
        end
        highRun++;
      end
      prevWeN = flWeN; prevOeN = flOeN; prevDqOe = flDqOe;
      prevAddr = flAddr; prevDout = flDqOut;
    end
  end

  task automatic runOp(bit e, logic [16:0] a, logic [7:0] d, int busy, bit stk, bit expErr);
    int waitN, el;
    wrCnt = 0; lowBad = 0; gapBad = 0; oeWeBad = 0; dqOeBad = 0; stabBad = 0;
    curErase = e; curBusy = busy; stuck = stk; riseCyc = cyc;
    @(negedge clk);
    reqValid = 1'b1; reqErase = e; reqAddr = a; reqData = d;
    chk(reqReady, "R10", "ready when idle", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    reqValid = 1'b1;
    chk(!reqReady, "R10", "ready while busy", reqReady, 0);
    @(negedge clk);
    reqValid = 1'b0;
    waitN = 0;
    while (!rspValid && waitN < 20000) begin @(negedge clk); waitN++; end
    el = cyc - riseCyc;
    chk(rspValid, "R8", "response arrives", rspValid, 1);
    chk(wrCnt == expCount(e), e ? "R3" : "R2", "write count", wrCnt, expCount(e));
    for (int i = 0; i < expCount(e) && i < wrCnt; i++) begin
      chk(wrAddr[i] == expAddr(e, i, a), e ? "R3" : "R2", "write address", wrAddr[i], expAddr(e, i, a));
      chk(wrData[i] == expData(e, i, d), e ? "R3" : "R2", "write data", wrData[i], expData(e, i, d));
    end
    chk(lowBad == 0, "R4", "WE low width errors", lowBad, 0);
    chk(gapBad == 0, "R4", "WE high gap errors", gapBad, 0);
    chk(stabBad == 0, "R5", "bus change in pulse", stabBad, 0);
    chk(oeWeBad == 0, "R6", "strobe overlap errors", oeWeBad, 0);
    chk(dqOeBad == 0, "R7", "turnaround errors", dqOeBad, 0);
    chk(rspError == expErr, expErr ? "R9" : "R8", "error flag", rspError, expErr);
    if (expErr) begin
      chk(el >= int'(e ? ERASE_TO : PROG_TO) && el <= int'(e ? ERASE_TO : PROG_TO) + 80,
          "R9", "timeout latency", el, e ? ERASE_TO : PROG_TO);
    end else begin
      chk(el >= busy && el <= busy + 80, "R8", "poll latency", el, busy);
    end
    repeat (3) @(negedge clk);
    chk(rspValid && rspError == expErr, "R10", "response held", rspValid, 1);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, "R10", "idle after response", reqReady, 1);
    stuck = 1'b0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    stuck = 1'b0; busyLeft = 0;
    repeat (3) @(negedge clk);
    chk(flCeN && flOeN && flWeN && !flDqOe && !reqReady == 1'b0 && !rspValid,
        "R1", "reset pin state", {flCeN, flOeN, flWeN, flDqOe, reqReady, rspValid}, 6'b111010);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && flCeN, "R1", "idle after reset", reqReady, 1);
    // directed corners
    runOp(1'b0, 17'h1ABCD, 8'h80, 0, 1'b0, 1'b0);
    runOp(1'b0, 17'h00001, 8'h3C, 0, 1'b0, 1'b0);
    runOp(1'b1, 17'h00000, 8'h00, 700, 1'b0, 1'b0);
    runOp(1'b0, 17'h0FFFF, 8'hC5, 0, 1'b1, 1'b1);
    runOp(1'b1, 17'h00000, 8'h00, 0, 1'b1, 1'b1);
    // random programs
    for (int k = 0; k < 10; k++) begin
      runOp(1'b0, 17'($urandom), 8'($urandom), int'($urandom % 600), 1'b0, 1'b0);
    end
    runOp(1'b1, 17'h0, 8'h0, int'($urandom % 300), 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule